// File: doc/BRIEF.md
# Time-multiplexed shared add/subtract unit

This block takes a pair of signed operands that arrive at a decimated rate, one new pair every fourth clock cycle at most, and computes four independent results from each pair with a single add/subtract datapath. A rotating two-bit slot index sets the function of that datapath and which operands reach it on every cycle. In the first slot it forms the sum, in the second the difference, in the third twice the first operand and in the fourth twice the second operand. No result feeds into another.

Each result is written into its own output register during its slot. The result of the current cycle, with its slot number, is also presented on a lane output. When the last slot has been written, a one-cycle strobe marks all four registers as complete and consistent. An operand strobe that arrives while the current pair is still being processed is dropped and raises a sticky error flag.

Top module: `tmx_addsub_top`

## Requirements
- R1: An `in_valid` sample on a clock edge is accepted, and `in_a`/`in_b` captured, when no pair is being processed or when the current pair is in its final slot (index 3). Starting one cycle after the accepting edge, `lane_valid` is high for four consecutive cycles with `lane_slot` equal to 0, 1, 2 and 3 in that order.
- R2: Slot 0 produces a + b on `lane_data` and writes it into `out_sum`.
- R3: Slot 1 produces a - b on `lane_data` and writes it into `out_diff`.
- R4: Slot 2 produces a + a on `lane_data` and writes it into `out_twice_a`.
- R5: Slot 3 produces b + b on `lane_data` and writes it into `out_twice_b`.
- R6: Operands are W-bit two's complement and results are W+1-bit two's complement. For every pair of operand values, all four results are exact and never wrap.
- R7: `out_valid` is high for exactly one cycle, in the cycle in which `lane_slot` is 3. At that point the four result registers hold the four results of the same pair. The registers keep their values until their own slot for a later pair is written.
- R8: An `in_valid` that arrives while slot 0, 1 or 2 is being computed is ignored: the remaining slots use the operands already captured. It also sets `overrun`, which stays high until reset.
- R9: Pairs that arrive exactly four cycles apart are all accepted, with no gap in the lane output and without setting `overrun`.
- R10: A synchronous active-high `rst` clears the slot sequencing, the operand and result registers, `out_valid`, `lane_valid`, `lane_data`, `lane_slot` and `overrun`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operand pair strobe |
| in_a | input | W | First operand, signed |
| in_b | input | W | Second operand, signed |
| out_sum | output | W+1 | Registered a + b |
| out_diff | output | W+1 | Registered a - b |
| out_twice_a | output | W+1 | Registered a + a |
| out_twice_b | output | W+1 | Registered b + b |
| out_valid | output | 1 | One-cycle strobe: all four result registers complete |
| lane_data | output | W+1 | Result written in the previous slot cycle |
| lane_slot | output | 2 | Slot index of `lane_data` |
| lane_valid | output | 1 | `lane_data` carries a result |
| overrun | output | 1 | Sticky flag: an operand strobe arrived too early |

## Verification
The bench builds the block with W = 4. At that width all 256 signed operand pairs can be streamed back to back at the four-cycle spacing. Every slot result is therefore compared with bench arithmetic across the full operand range, including both extremes, where the sum, difference and doublings reach the limits of the W+1-bit result. The small width also leaves room for a separate early-strobe scenario and for reset checks.

// File: rtl/tmx_pkg.sv
package tmx_pkg;
  localparam int SLOT_COUNT = 4;
  localparam int SLOT_W     = $clog2(SLOT_COUNT);

  typedef logic [SLOT_W-1:0] slot_t;
  localparam slot_t LAST_SLOT = slot_t'(SLOT_COUNT - 1);

  typedef enum logic { OP_ADD = 1'b0, OP_SUB = 1'b1 } op_e;
  typedef enum logic { SRC_A = 1'b0, SRC_B = 1'b1 } src_e;

  typedef struct packed {
    src_e x_src;
    src_e y_src;
    op_e  op;
  } slot_plan_t;

  // Fixed schedule: slot index to operand routing and function
  function automatic slot_plan_t plan_for(slot_t s);
    slot_plan_t p;
    case (s)
      2'd0:    p = '{x_src: SRC_A, y_src: SRC_B, op: OP_ADD};
      2'd1:    p = '{x_src: SRC_A, y_src: SRC_B, op: OP_SUB};
      2'd2:    p = '{x_src: SRC_A, y_src: SRC_A, op: OP_ADD};
      default: p = '{x_src: SRC_B, y_src: SRC_B, op: OP_ADD};
    endcase
    return p;
  endfunction
endpackage

// File: rtl/tmx_sched.sv
module tmx_sched
  import tmx_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  in_valid,
  output logic  accept,
  output logic  busy,
  output slot_t slot,
  output logic  all_done,
  output logic  overrun
);
  logic  busy_q;
  slot_t slot_q;
  logic  done_q;
  logic  ovr_q;
  logic  last_slot;
  logic  early_strobe;

  assign last_slot    = busy_q && (slot_q == LAST_SLOT);
  assign accept       = in_valid && (!busy_q || last_slot);
  assign early_strobe = in_valid && !accept;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      slot_q <= '0;
      done_q <= 1'b0;
      ovr_q  <= 1'b0;
    end else begin
      done_q <= last_slot;
      if (accept) begin
        busy_q <= 1'b1;
        slot_q <= '0;
      end else if (busy_q) begin
        slot_q <= slot_q + slot_t'(1);
        if (last_slot) busy_q <= 1'b0;
      end
      if (early_strobe) ovr_q <= 1'b1;
    end
  end

  assign busy     = busy_q;
  assign slot     = slot_q;
  assign all_done = done_q;
  assign overrun  = ovr_q;

  // R8: once raised, the error flag only falls through reset
  assert_overrun_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    overrun |=> overrun);

  // R8: the flag rises only after an operand strobe
  assert_overrun_cause_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(overrun) |-> $past(in_valid));

  // R1: while idle the slot index does not move
  assert_idle_slot_hold_R1: assert property (@(posedge clk) disable iff (rst)
    (!busy && !in_valid) |=> $stable(slot));
endmodule

// File: rtl/tmx_addsub.sv
module tmx_addsub
  import tmx_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  input  slot_t        slot,
  output logic [W:0]   result
);
  localparam int RW = W + 1;

  // Sign-extend a W-bit operand to the result width
  function automatic logic [RW-1:0] widen(logic [W-1:0] v);
    return {v[W-1], v};
  endfunction

  // One shared add/subtract: width W+1 cannot wrap for W-bit inputs
  function automatic logic [RW-1:0] addsub(logic [RW-1:0] x, logic [RW-1:0] y, op_e op);
    return (op == OP_SUB) ? (x - y) : (x + y);
  endfunction

  slot_plan_t    plan;
  logic [RW-1:0] x_in;
  logic [RW-1:0] y_in;

  always_comb begin
    plan   = plan_for(slot);
    x_in   = (plan.x_src == SRC_A) ? widen(op_a) : widen(op_b);
    y_in   = (plan.y_src == SRC_A) ? widen(op_a) : widen(op_b);
    result = addsub(x_in, y_in, plan.op);
  end
endmodule

// File: rtl/tmx_result_bank.sv
module tmx_result_bank
  import tmx_pkg::*;
#(
  parameter int W = 16
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         wr_en,
  input  slot_t                        wr_slot,
  input  logic [W:0]                   wr_data,
  output logic [SLOT_COUNT-1:0][W:0]   bank,
  output logic [W:0]                   lane_data,
  output slot_t                        lane_slot,
  output logic                         lane_valid
);
  logic [SLOT_COUNT-1:0][W:0] bank_q;

  for (genvar g = 0; g < SLOT_COUNT; g++) begin : g_slot_reg
    always_ff @(posedge clk) begin
      if (rst)                                  bank_q[g] <= '0;
      else if (wr_en && (wr_slot == slot_t'(g))) bank_q[g] <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lane_data  <= '0;
      lane_slot  <= '0;
      lane_valid <= 1'b0;
    end else begin
      lane_valid <= wr_en;
      if (wr_en) begin
        lane_data <= wr_data;
        lane_slot <= wr_slot;
      end
    end
  end

  assign bank = bank_q;

  // R4/R5: doubling slots always deliver an even value
  assert_double_even_R4: assert property (@(posedge clk) disable iff (rst)
    (lane_valid && lane_slot[1]) |-> (lane_data[0] == 1'b0));

  // R2: the lane value of slot 0 matches the sum register
  assert_sum_lane_R2: assert property (@(posedge clk) disable iff (rst)
    (lane_valid && lane_slot == 2'd0) |-> (lane_data == bank_q[0]));
endmodule

// File: rtl/tmx_addsub_top.sv
module tmx_addsub_top
  import tmx_pkg::*;
#(
  parameter int W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [W-1:0]     in_a,
  input  logic [W-1:0]     in_b,
  output logic [W:0]       out_sum,
  output logic [W:0]       out_diff,
  output logic [W:0]       out_twice_a,
  output logic [W:0]       out_twice_b,
  output logic             out_valid,
  output logic [W:0]       lane_data,
  output logic [1:0]       lane_slot,
  output logic             lane_valid,
  output logic             overrun
);
  logic                       accept;
  logic                       busy;
  slot_t                      slot;
  logic [W-1:0]               a_q;
  logic [W-1:0]               b_q;
  logic [W:0]                 alu_y;
  logic [SLOT_COUNT-1:0][W:0] bank;

  tmx_sched u_sched (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .accept   (accept),
    .busy     (busy),
    .slot     (slot),
    .all_done (out_valid),
    .overrun  (overrun)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      a_q <= '0;
      b_q <= '0;
    end else if (accept) begin
      a_q <= in_a;
      b_q <= in_b;
    end
  end

  tmx_addsub #(.W(W)) u_alu (
    .op_a   (a_q),
    .op_b   (b_q),
    .slot   (slot),
    .result (alu_y)
  );

  tmx_result_bank #(.W(W)) u_bank (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (busy),
    .wr_slot    (slot),
    .wr_data    (alu_y),
    .bank       (bank),
    .lane_data  (lane_data),
    .lane_slot  (lane_slot),
    .lane_valid (lane_valid)
  );

  assign out_sum     = bank[0];
  assign out_diff    = bank[1];
  assign out_twice_a = bank[2];
  assign out_twice_b = bank[3];

  // R7: completion strobe coincides with the final lane slot
  assert_done_on_last_R7: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (lane_valid && lane_slot == 2'd3));

  // R7: completion strobe lasts a single cycle
  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (rst)
    out_valid |=> !out_valid);

  // R6: (a+b) + (a-b) equals 2a exactly when the set is complete
  assert_no_overflow_R6: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (($signed({out_sum[W], out_sum}) + $signed({out_diff[W], out_diff}))
                   == $signed({out_twice_a[W], out_twice_a})));

  // R1: slot indices on the lane climb by one until the last slot
  assert_slot_order_R1: assert property (@(posedge clk) disable iff (rst)
    (lane_valid && lane_slot != 2'd3) |=> (lane_valid && lane_slot == $past(lane_slot) + 2'd1));
endmodule

// File: tb/tmx_addsub_top_tb_top.sv
module tmx_addsub_top_tb_top;
  localparam int TW     = 4;
  localparam int CLK_NS = 10;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          in_valid = 1'b0;
  logic [TW-1:0] in_a = '0;
  logic [TW-1:0] in_b = '0;
  logic [TW:0]   out_sum, out_diff, out_twice_a, out_twice_b, lane_data;
  logic          out_valid, lane_valid, overrun;
  logic [1:0]    lane_slot;

  int n_chk  = 0;
  int n_fail = 0;

  always #(CLK_NS/2) clk = ~clk;

  tmx_addsub_top #(.W(TW)) dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_a(in_a), .in_b(in_b),
    .out_sum(out_sum), .out_diff(out_diff), .out_twice_a(out_twice_a),
    .out_twice_b(out_twice_b), .out_valid(out_valid), .lane_data(lane_data),
    .lane_slot(lane_slot), .lane_valid(lane_valid), .overrun(overrun)
  );

  function automatic int sv(logic [TW:0] v);
    return int'($signed(v));
  endfunction

  function automatic int expect_slot(int k, int a, int b);
    case (k)
      0:       return a + b;
      1:       return a - b;
      2:       return 2 * a;
      default: return 2 * b;
    endcase
  endfunction

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check_lane(int k, int a, int b);
    chk("R1 lane_valid", int'(lane_valid), 1);
    chk("R1 lane_slot", int'(lane_slot), k);
    case (k)
      0: chk("R2 slot0 a+b", sv(lane_data), expect_slot(k, a, b));
      1: chk("R3 slot1 a-b", sv(lane_data), expect_slot(k, a, b));
      2: chk("R4 slot2 a+a", sv(lane_data), expect_slot(k, a, b));
      default: chk("R5 slot3 b+b", sv(lane_data), expect_slot(k, a, b));
    endcase
  endtask

  task automatic check_set(string tag, int a, int b);
    chk({tag, " R2 out_sum"}, sv(out_sum), a + b);
    chk({tag, " R3 out_diff"}, sv(out_diff), a - b);
    chk({tag, " R4 out_twice_a"}, sv(out_twice_a), 2 * a);
    chk({tag, " R5 out_twice_b"}, sv(out_twice_b), 2 * b);
  endtask

  task automatic check_cleared();
    chk("R10 out_valid", int'(out_valid), 0);
    chk("R10 lane_valid", int'(lane_valid), 0);
    chk("R10 lane_slot", int'(lane_slot), 0);
    chk("R10 lane_data", sv(lane_data), 0);
    chk("R10 overrun", int'(overrun), 0);
    check_set("R10", 0, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    int pa = 0;
    int pb = 0;
    bit have = 1'b0;

    repeat (3) @(posedge clk);
    @(negedge clk);
    check_cleared();
    rst = 1'b0;
    step();
    chk("R1 idle lane_valid", int'(lane_valid), 0);

    // R6/R9: every operand pair, back to back at four-cycle spacing
    for (int a = -(1 << (TW-1)); a < (1 << (TW-1)); a++) begin
      for (int b = -(1 << (TW-1)); b < (1 << (TW-1)); b++) begin
        in_valid = 1'b1;
        in_a = TW'(a);
        in_b = TW'(b);
        step();
        in_valid = 1'b0;
        if (have) begin
          chk("R7 out_valid", int'(out_valid), 1);
          check_lane(3, pa, pb);
          check_set("R6 R9", pa, pb);
        end
        chk("R9 overrun", int'(overrun), 0);
        for (int k = 0; k < 3; k++) begin
          step();
          check_lane(k, a, b);
          chk("R7 out_valid low", int'(out_valid), 0);
        end
        pa = a;
        pb = b;
        have = 1'b1;
      end
    end
    step();
    chk("R7 out_valid final", int'(out_valid), 1);
    check_lane(3, pa, pb);
    check_set("R7 final", pa, pb);
    step();
    chk("R7 pulse ends", int'(out_valid), 0);
    chk("R7 lane idle", int'(lane_valid), 0);
    check_set("R7 held", pa, pb);

    // R8: early strobe is ignored and flagged
    in_valid = 1'b1; in_a = TW'(5); in_b = TW'(-3);
    step();
    in_valid = 1'b0;
    step();
    check_lane(0, 5, -3);
    in_valid = 1'b1; in_a = TW'(-8); in_b = TW'(7);
    step();
    in_valid = 1'b0;
    chk("R8 overrun set", int'(overrun), 1);
    check_lane(1, 5, -3);
    step();
    check_lane(2, 5, -3);
    step();
    check_lane(3, 5, -3);
    chk("R8 out_valid", int'(out_valid), 1);
    check_set("R8 operands kept", 5, -3);
    step();
    chk("R8 no extra pass", int'(lane_valid), 0);
    chk("R8 sticky", int'(overrun), 1);

    // Overrun stays set across a later well-spaced pair
    in_valid = 1'b1; in_a = TW'(-1); in_b = TW'(2);
    step();
    in_valid = 1'b0;
    for (int k = 0; k < 4; k++) begin
      step();
      check_lane(k, -1, 2);
    end
    chk("R8 still sticky", int'(overrun), 1);

    // R10: reset clears everything
    rst = 1'b1;
    step();
    rst = 1'b0;
    check_cleared();

    $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule